// File: doc/BRIEF.md
# Byte-Paired Control Register Bank with Interrupt

This block holds a bank of 16-bit control registers that a microcontroller with an 8-bit data bus reaches through byte offsets. Each register occupies two neighbouring offsets. The even offset carries bits 7:0 and the odd offset carries bits 15:8. A write takes two byte cycles, low byte first. The low byte waits in a staging register, and the full word updates in one step when the matching high byte arrives. A read also takes two byte cycles. Reading the low byte captures the high byte at the same moment, so the pair of reads returns one consistent snapshot.

Register 0 is the control word, and it also governs the interrupt. A capture-finished pulse or a compression-finished pulse sets a pending flag. The active-low interrupt output is low while that flag is set and the enable bit (bit 6 of register 0) is one. Committing register 0 with bit 6 zero masks the output but keeps the pending flag. Committing register 0 with bit 5 one clears the pending flag. Bit 5 is never stored, so it always reads back as zero.

Top module: `byte_pair_regbank`

## Requirements
- R1: After reset every register is 0x0000, `irq_n` is 1 and `rdata` is 0x00.
- R2: A write to an even offset 2k stages the byte, and register k keeps its old value.
- R3: A write to offset 2k+1 is a commit if the most recent earlier write (idle and read cycles between them are allowed) went to offset 2k. One cycle after a commit, register k equals {high byte, staged byte}.
- R4: A write to an odd offset that is not a commit as defined in R3 changes no register. This covers a second odd write after a commit.
- R5: While `rd` is high at an even offset 2k, `rdata` shows bits 7:0 of register k in the same cycle, and bits 15:8 are captured. While `rd` is high at any odd offset, `rdata` shows the last captured byte, even if the register has changed since.
- R6: A one-cycle pulse on `capture_done` or `compress_done` sets the pending flag. One cycle later `irq_n` is 0 if bit 6 of register 0 is 1.
- R7: While bit 6 of register 0 is 0, `irq_n` is 1. The pending flag is kept, and setting bit 6 again drives `irq_n` low.
- R8: A commit to register 0 with bit 5 set clears the pending flag. Bit 5 of register 0 always reads as 0.
- R9: If an event pulse and a clearing commit to register 0 fall in the same cycle, the pending flag ends up set.
- R10: While `rd` is 0, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ofs | input | IDX_W+1 | Byte offset; bit 0 selects the high byte |
| wdata | input | 8 | Write byte |
| wr | input | 1 | Write strobe, one byte per cycle |
| rd | input | 1 | Read strobe |
| capture_done | input | 1 | Capture-finished event pulse |
| compress_done | input | 1 | Compression-finished event pulse |
| rdata | output | 8 | Read byte, combinational while `rd` is high |
| regs_flat | output | 16*NUM_REGS | All register values; register k at bits 16k+15:16k |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions collide in register 0. An event pulse can arrive in the same cycle as the high-byte commit that clears the pending flag. The bench provokes this by raising `capture_done` together with the odd-offset write of a value that has bit 5 set. It then checks that `irq_n` stays low afterwards and that a later clear brings it back high. A second collision is a low-byte read that captures a register while a commit to that same register is in flight. The odd read must return the pre-commit high byte, and the reference model's value decides the outcome on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef logic [15:0] word_t;
  typedef logic [7:0]  byte_t;

  localparam int CTRL_IDX    = 0;
  localparam int IRQ_CLR_BIT = 5;
  localparam int IRQ_EN_BIT  = 6;
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/rb_write_pair.sv
module rb_write_pair
  import regbank_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             hi_sel,
  input  logic [IDX_W-1:0] idx,
  input  byte_t            wdata,
  output logic             commit_vld,
  output logic [IDX_W-1:0] commit_idx,
  output word_t            commit_data
);
  byte_t            stage_q, stage_d;
  logic [IDX_W-1:0] sidx_q, sidx_d;
  logic             sval_q, sval_d;
  logic             lo_wr, hi_wr;

  assign lo_wr = wr & ~hi_sel;
  assign hi_wr = wr &  hi_sel;

  always_comb begin
    stage_d = stage_q;
    sidx_d  = sidx_q;
    sval_d  = sval_q;
    if (lo_wr) begin
      stage_d = wdata;
      sidx_d  = idx;
      sval_d  = 1'b1;
    end else if (hi_wr) begin
      sval_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      sidx_q  <= '0;
      sval_q  <= 1'b0;
    end else if (wr) begin
      stage_q <= stage_d;
      sidx_q  <= sidx_d;
      sval_q  <= sval_d;
    end
  end

  assign commit_vld  = hi_wr & sval_q & (sidx_q == idx);
  assign commit_idx  = idx;
  assign commit_data = {wdata, stage_q};
endmodule

// File: rtl/rb_reg_array.sv
module rb_reg_array
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_vld,
  input  logic [IDX_W-1:0]      commit_idx,
  input  word_t                 commit_data,
  output logic [16*NUM_REGS-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    word_t q, d;
    logic  we;

    assign we = commit_vld && (commit_idx == IDX_W'(i));

    if (i == CTRL_IDX) begin : g_ctrl
      always_comb begin
        d = q;
        if (we) begin
          d = commit_data;
          d[IRQ_CLR_BIT] = 1'b0;
        end
      end
    end else begin : g_plain
      always_comb begin
        d = q;
        if (we) d = commit_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end

    assign regs_flat[16*i +: 16] = q;
  end
endmodule

// File: rtl/rb_read_port.sv
module rb_read_port
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd,
  input  logic                   hi_sel,
  input  logic [IDX_W-1:0]       idx,
  input  logic [16*NUM_REGS-1:0] regs_flat,
  output byte_t                  rdata
);
  word_t words [NUM_REGS];
  byte_t hi_q, hi_d;
  logic  lo_rd;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
    assign words[i] = regs_flat[16*i +: 16];
  end

  assign lo_rd = rd & ~hi_sel;

  always_comb begin
    hi_d = hi_q;
    if (lo_rd) hi_d = words[idx][15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (lo_rd) hi_q <= hi_d;
  end

  always_comb begin
    rdata = '0;
    if (rd) rdata = hi_sel ? hi_q : words[idx][7:0];
  end
endmodule

// File: rtl/rb_irq.sv
module rb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_done,
  input  logic compress_done,
  input  logic clr,
  input  logic en,
  output logic irq_n
);
  logic pend_q, pend_d, evt;

  assign evt = capture_done | compress_done;

  always_comb begin
    pend_d = pend_q;
    if (evt)      pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (evt | clr)  pend_q <= pend_d;
  end

  assign irq_n = ~(pend_q & en);
endmodule

// File: rtl/byte_pair_regbank.sv
module byte_pair_regbank
  import regbank_pkg::*;
#(
  parameter  int NUM_REGS = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W:0]         ofs,
  input  logic [7:0]             wdata,
  input  logic                   wr,
  input  logic                   rd,
  input  logic                   capture_done,
  input  logic                   compress_done,
  output logic [7:0]             rdata,
  output logic [16*NUM_REGS-1:0] regs_flat,
  output logic                   irq_n
);
  logic             rst_s_n;
  logic             hi_sel;
  logic [IDX_W-1:0] idx;
  logic             commit_vld;
  logic [IDX_W-1:0] commit_idx;
  word_t            commit_data;
  logic             irq_clr;

  assign hi_sel = ofs[0];
  assign idx    = ofs[IDX_W:1];

  rb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  rb_write_pair #(.IDX_W(IDX_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .wr          (wr),
    .hi_sel      (hi_sel),
    .idx         (idx),
    .wdata       (wdata),
    .commit_vld  (commit_vld),
    .commit_idx  (commit_idx),
    .commit_data (commit_data)
  );

  rb_reg_array #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .commit_vld  (commit_vld),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .regs_flat   (regs_flat)
  );

  rb_read_port #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rd        (rd),
    .hi_sel    (hi_sel),
    .idx       (idx),
    .regs_flat (regs_flat),
    .rdata     (rdata)
  );

  assign irq_clr = commit_vld && (commit_idx == IDX_W'(CTRL_IDX))
                   && commit_data[IRQ_CLR_BIT];

  rb_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .capture_done  (capture_done),
    .compress_done (compress_done),
    .clr           (irq_clr),
    .en            (regs_flat[16*CTRL_IDX + IRQ_EN_BIT]),
    .irq_n         (irq_n)
  );
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter  int NUM_REGS = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IDX_W:0]         ofs,
  input logic [7:0]             wdata,
  input logic                   wr,
  input logic                   rd,
  input logic                   capture_done,
  input logic                   compress_done,
  input logic [7:0]             rdata,
  input logic [16*NUM_REGS-1:0] regs_flat,
  input logic                   irq_n
);
  logic             last_lo_q;
  logic [IDX_W-1:0] last_idx_q;
  logic             pairs;
  logic [15:0]      words [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_w
    assign words[i] = regs_flat[16*i +: 16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_lo_q  <= 1'b0;
      last_idx_q <= '0;
    end else if (wr) begin
      last_lo_q  <= ~ofs[0];
      last_idx_q <= ofs[IDX_W:1];
    end
  end

  assign pairs = last_lo_q && (last_idx_q == ofs[IDX_W:1]);

  // R4
  unpaired_hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ofs[0] && !pairs) |=> $stable(regs_flat));

  // R3
  paired_hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ofs[0] && pairs) |=> (words[$past(ofs[IDX_W:1])][15:8] == $past(wdata)));

  // R8
  clr_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[5] == 1'b0);

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == 8'h00));

  // R7
  masked_irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_flat[6] |-> irq_n);

  // R6
  event_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((capture_done || compress_done) && regs_flat[6] && !wr) |=> !irq_n);
endmodule

bind byte_pair_regbank rb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_s_n),
  .ofs           (ofs),
  .wdata         (wdata),
  .wr            (wr),
  .rd            (rd),
  .capture_done  (capture_done),
  .compress_done (compress_done),
  .rdata         (rdata),
  .regs_flat     (regs_flat),
  .irq_n         (irq_n)
);

// File: tb/sim_byte_pair_regbank.sv
`timescale 1ns/1ps
module sim_byte_pair_regbank;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW:0]   ofs;
  logic [7:0]    wdata;
  logic          wr, rd, cap, cmp;
  logic [7:0]    rdata;
  logic [16*N-1:0] regs_flat;
  logic          irq_n;

  always #2.5 clk = ~clk;

  byte_pair_regbank #(.NUM_REGS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ofs(ofs), .wdata(wdata), .wr(wr), .rd(rd),
    .capture_done(cap), .compress_done(cmp), .rdata(rdata),
    .regs_flat(regs_flat), .irq_n(irq_n)
  );

  // reference model state
  int m_reg [N];
  int m_stage, m_sidx, m_hi;
  bit m_sval, m_pend;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int exp_rd, exp_irq, regs_ok;
    int idx;
    idx = int'(ofs[IW:1]);
    exp_rd = !rd ? 0 : (ofs[0] ? m_hi : (m_reg[idx] & 8'hFF));
    exp_irq = (m_pend && ((m_reg[0] >> 6) & 1)) ? 0 : 1;
    chk(tag, "rdata", int'(rdata), exp_rd);
    chk(tag, "irq_n", int'(irq_n), exp_irq);
    regs_ok = 1;
    for (int i = 0; i < N; i++)
      if (int'(regs_flat[16*i +: 16]) != m_reg[i]) begin
        chk(tag, $sformatf("reg%0d", i), int'(regs_flat[16*i +: 16]), m_reg[i]);
        regs_ok = 0;
      end
    if (regs_ok) chk(tag, "regs", 1, 1);
  endtask

  task automatic model_edge();
    int idx, val;
    bit clr;
    idx = int'(ofs[IW:1]);
    clr = 0;
    if (rd && !ofs[0]) m_hi = (m_reg[idx] >> 8) & 8'hFF;
    if (wr) begin
      if (!ofs[0]) begin
        m_stage = int'(wdata); m_sidx = idx; m_sval = 1;
      end else begin
        if (m_sval && m_sidx == idx) begin
          val = (int'(wdata) << 8) | m_stage;
          if (idx == 0) begin
            clr = ((val >> 5) & 1) != 0;
            val = val & ~32'h20;
          end
          m_reg[idx] = val;
        end
        m_sval = 0;
      end
    end
    if (cap || cmp) m_pend = 1;
    else if (clr)   m_pend = 0;
  endtask

  // one bus cycle: drive, compare, then advance model at the edge
  task automatic cyc(string tag, bit w, bit r, int o, int d, bit c1 = 0, bit c2 = 0);
    @(negedge clk);
    wr = w; rd = r; ofs = (IW+1)'(o); wdata = 8'(d); cap = c1; cmp = c2;
    #1;
    compare(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr16(string tag, int k, int v);
    cyc(tag, 1, 0, 2*k, v & 8'hFF);
    cyc(tag, 1, 0, 2*k+1, (v >> 8) & 8'hFF);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_reg[i] = 0;
    m_stage = 0; m_sidx = 0; m_hi = 0; m_sval = 0; m_pend = 0;
    rst_n = 1'b0; wr = 0; rd = 0; ofs = '0; wdata = '0; cap = 0; cmp = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    idle("R1");
    // R2 low byte stays staged
    cyc("R2", 1, 0, 4, 8'h34);
    idle("R2");
    // R3 commit
    cyc("R3", 1, 0, 5, 8'h12);
    idle("R3");
    // R4 second odd write ignored
    cyc("R4", 1, 0, 5, 8'h99);
    idle("R4");
    // R4 odd write to another register ignored
    cyc("R4", 1, 0, 6, 8'hAA);
    cyc("R4", 1, 0, 9, 8'h55);
    cyc("R4", 1, 0, 7, 8'h77);
    idle("R4");
    // R3 idle and read between halves still pair
    cyc("R3", 1, 0, 8, 8'h11);
    idle("R3");
    cyc("R3", 0, 1, 4, 0);
    cyc("R3", 1, 0, 9, 8'h22);
    idle("R3");
    // R5 snapshot read across a concurrent commit
    cyc("R5", 0, 1, 4, 0);
    cyc("R5", 1, 0, 4, 8'h78);
    cyc("R5", 1, 0, 5, 8'h56);
    cyc("R5", 0, 1, 5, 0);
    cyc("R5", 0, 1, 4, 0);
    cyc("R5", 0, 1, 5, 0);
    // R5 read in same cycle as the commit to that register
    cyc("R5", 1, 0, 4, 8'hCD);
    cyc("R5", 1, 1, 5, 8'hAB);
    cyc("R5", 0, 1, 4, 0);
    cyc("R5", 0, 1, 5, 0);
    // R10 idle rdata
    idle("R10");
    // fill all registers, read back
    for (int k = 1; k < N; k++) wr16("R3", k, (k * 16'h1357) ^ 16'hA5C3);
    for (int k = 0; k < N; k++) begin
      cyc("R5", 0, 1, 2*k, 0);
      cyc("R5", 0, 1, 2*k+1, 0);
    end
    // R6 enable then capture
    wr16("R6", 0, 16'h0040);
    cyc("R6", 0, 0, 0, 0, 1, 0);
    idle("R6");
    // R8 clear, bit 5 reads zero
    wr16("R8", 0, 16'h0060);
    idle("R8");
    cyc("R8", 0, 1, 0, 0);
    // R6 compress event
    cyc("R6", 0, 0, 0, 0, 0, 1);
    idle("R6");
    // R7 mask keeps pending
    wr16("R7", 0, 16'h0000);
    idle("R7");
    cyc("R7", 0, 0, 0, 0, 1, 0);
    idle("R7");
    wr16("R7", 0, 16'h0040);
    idle("R7");
    wr16("R8", 0, 16'h0060);
    idle("R8");
    // R9 event together with clearing commit
    cyc("R9", 1, 0, 0, 8'h60);
    cyc("R9", 1, 0, 1, 8'h00, 1, 0);
    idle("R9");
    idle("R9");
    wr16("R9", 0, 16'h0060);
    idle("R9");
    idle("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule